// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block decides when one processor core's clock, core-logic power and cache RAM power are on, and it steps the core through four idle depths. The lightest depth is clock-gated standby. Below it are dormant, where the cache RAMs keep their contents; power-down, where both power domains are off; and hot-unplugged, where the core can only be brought back by an explicit plug-in request. All deep entries follow the same handshake. The sequencer first isolates the core from the coherence domain. It then waits for software to confirm that the state save is complete, and only after that removes power.

On the way back the sequencer restores power and waits for the supply to report good. It then holds the core in reset for a fixed number of cycles before it enables the clock. A wake source that arrives while an entry handshake is still pending cancels the entry. For a dormant or power-down target that means an interrupt, an event, a send-event or a snoop. For a hot-unplug target only a plug-in request cancels it. Each output is registered, and a 3-bit code reports where the sequencer is.

Top module: `core_pwr_seq`

## Requirements
- R1: During and after synchronous reset the sequencer is in run: clock enable 1, core power 1, RAM power 1, core reset 0, isolation request 0, state code 0.
- R2: In run with no deeper request, a wait-for-interrupt or wait-for-event request enters standby one clock edge later. In standby the clock enable is 0, both power enables stay 1, and the state code is 1.
- R3: Standby is left on an interrupt, an event, a send-event or a snoop request. With none of these present it remains in standby.
- R4: When a wake source is sampled in standby, the state code is 5 with the clock still gated after that edge. After the next edge the state is run with the clock enabled.
- R5: A wait-for-interrupt or wait-for-event request that is sampled together with an active standby wake source leaves the core in run.
- R6: A dormant, power-down or hot-unplug request raises the isolation request, with state code 5 and both powers still on. The sequencer waits for the isolation acknowledge and then for save-done before it removes any power.
- R7: Dormant has core power 0, RAM power 1, isolation 1, core reset 1 and code 2. A snoop request does not wake it, while an interrupt, event or send-event does.
- R8: Power-down has core power 0, RAM power 0, isolation 1, core reset 1 and code 3. An interrupt, event or send-event starts the exit.
- R9: Hot-unplugged has both powers 0 and code 4. Interrupt, event, send-event and snoop lines neither wake it nor cancel its entry. Only the plug-in request starts the exit.
- R10: A valid wake source sampled while waiting for isolation acknowledge or save-done returns the sequencer to run at that edge, with the isolation request dropped.
- R11: On exit, both powers turn on with core reset 1, clock 0, isolation 1 and code 5 until power-good is sampled. From that edge reset is held for exactly RST_CYC (default 4) cycles. The core then runs with reset released, clock enabled and isolation dropped.
- R12: Simultaneous deep requests are prioritised hot-unplug over power-down over dormant over standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Core waits for interrupt |
| wfe_req | input | 1 | Core waits for event |
| irq | input | 1 | Interrupt pending |
| evt | input | 1 | External event |
| sev | input | 1 | Send-event broadcast |
| snoop_req | input | 1 | Coherence request from the snoop logic |
| dormant_req | input | 1 | Software asks for dormant |
| pdown_req | input | 1 | Software asks for power-down |
| unplug_req | input | 1 | Software asks for hot-unplug |
| plugin_req | input | 1 | Software asks to plug the core back in |
| save_done | input | 1 | Core state save finished |
| pwr_good | input | 1 | Core supply is stable |
| iso_ack | input | 1 | Coherence isolation complete |
| core_clk_en | output | 1 | Core clock enable |
| core_pwr_en | output | 1 | Core logic power enable |
| ram_pwr_en | output | 1 | Cache RAM power enable |
| core_rst | output | 1 | Core reset |
| iso_req | output | 1 | Coherence isolation request |
| state_code | output | 3 | 0 run, 1 standby, 2 dormant, 3 power-down, 4 hot-unplugged, 5 transitioning |

## Verification
The bench builds the sequencer with the default RST_CYC of 4, so each reset-hold window is short enough to be checked cycle by cycle against an exact count after power-good. With this value, every depth can be entered and left in one short run. The run covers each standby wake source, cancellation in both handshake phases, and the case where interrupts must stay ignored while hot-unplugged.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [3:0] {
    S_RUN, S_STBY, S_WAKE, S_ISO, S_SAVE,
    S_DORM, S_PDN, S_UNPL, S_PUP, S_RHOLD
  } cps_state_e;

  typedef enum logic [1:0] {T_DORM, T_PDN, T_UNPL} cps_tgt_e;

  localparam logic [2:0] C_RUN   = 3'd0;
  localparam logic [2:0] C_STBY  = 3'd1;
  localparam logic [2:0] C_DORM  = 3'd2;
  localparam logic [2:0] C_PDN   = 3'd3;
  localparam logic [2:0] C_UNPL  = 3'd4;
  localparam logic [2:0] C_TRANS = 3'd5;

  typedef struct packed {
    logic       clk_en;
    logic       pwr_en;
    logic       ram_en;
    logic       rst;
    logic       iso;
    logic [2:0] code;
  } cps_out_t;

  localparam cps_out_t OUT_RUN = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, C_RUN};
endpackage

// File: rtl/cps_wake_filter.sv
module cps_wake_filter
  import cps_pkg::*;
(
  input  logic     irq,
  input  logic     evt,
  input  logic     sev,
  input  logic     snoop_req,
  input  logic     plugin_req,
  input  cps_tgt_e tgt,
  output logic     wake_stby,
  output logic     wake_off,
  output logic     abort_entry,
  output logic     plug_in
);
  // Standby keeps coherence alive, so snoops wake it.
  assign wake_stby = irq | evt | sev | snoop_req;
  // Isolated powered-off cores do not answer snoops.
  assign wake_off  = irq | evt | sev;
  // Entry cancel depends on the requested depth.
  assign abort_entry = (tgt == T_UNPL) ? plugin_req : wake_stby;
  assign plug_in   = plugin_req;
endmodule

// File: rtl/cps_rst_timer.sv
module cps_rst_timer #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (RST_CYC < 2) ? 1 : $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cps_out_reg.sv
module cps_out_reg
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cps_state_e state_d,
  output cps_out_t   out_q
);
  cps_out_t nxt;

  always_comb begin
    unique case (state_d)
      S_RUN:   nxt = OUT_RUN;
      S_STBY:  nxt = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, C_STBY};
      S_WAKE:  nxt = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, C_TRANS};
      S_ISO,
      S_SAVE:  nxt = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, C_TRANS};
      S_DORM:  nxt = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, C_DORM};
      S_PDN:   nxt = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, C_PDN};
      S_UNPL:  nxt = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, C_UNPL};
      S_PUP,
      S_RHOLD: nxt = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, C_TRANS};
      default: nxt = OUT_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= OUT_RUN;
    else     out_q <= nxt;
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi_req,
  input  logic       wfe_req,
  input  logic       irq,
  input  logic       evt,
  input  logic       sev,
  input  logic       snoop_req,
  input  logic       dormant_req,
  input  logic       pdown_req,
  input  logic       unplug_req,
  input  logic       plugin_req,
  input  logic       save_done,
  input  logic       pwr_good,
  input  logic       iso_ack,
  output logic       core_clk_en,
  output logic       core_pwr_en,
  output logic       ram_pwr_en,
  output logic       core_rst,
  output logic       iso_req,
  output logic [2:0] state_code
);
  cps_state_e state_q, state_d;
  cps_tgt_e   tgt_q, tgt_d;
  logic       wake_stby, wake_off, abort_entry, plug_in, hold_done;
  cps_out_t   out_q;

  cps_wake_filter u_wake (
    .irq        (irq),
    .evt        (evt),
    .sev        (sev),
    .snoop_req  (snoop_req),
    .plugin_req (plugin_req),
    .tgt        (tgt_q),
    .wake_stby  (wake_stby),
    .wake_off   (wake_off),
    .abort_entry(abort_entry),
    .plug_in    (plug_in)
  );

  cps_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (state_q == S_RHOLD),
    .done_o(hold_done)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      S_RUN: begin
        if (unplug_req) begin
          tgt_d = T_UNPL; state_d = S_ISO;
        end else if (pdown_req) begin
          tgt_d = T_PDN;  state_d = S_ISO;
        end else if (dormant_req) begin
          tgt_d = T_DORM; state_d = S_ISO;
        end else if ((wfi_req || wfe_req) && !wake_stby) begin
          state_d = S_STBY;
        end
      end
      S_STBY:  if (wake_stby) state_d = S_WAKE;
      S_WAKE:  state_d = S_RUN;
      S_ISO: begin
        if (abort_entry)  state_d = S_RUN;
        else if (iso_ack) state_d = S_SAVE;
      end
      S_SAVE: begin
        if (abort_entry) state_d = S_RUN;
        else if (save_done) begin
          unique case (tgt_q)
            T_DORM:  state_d = S_DORM;
            T_PDN:   state_d = S_PDN;
            default: state_d = S_UNPL;
          endcase
        end
      end
      S_DORM,
      S_PDN:   if (wake_off)  state_d = S_PUP;
      S_UNPL:  if (plug_in)   state_d = S_PUP;
      S_PUP:   if (pwr_good)  state_d = S_RHOLD;
      S_RHOLD: if (hold_done) state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_RUN;
      tgt_q   <= T_DORM;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  cps_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .out_q  (out_q)
  );

  assign core_clk_en = out_q.clk_en;
  assign core_pwr_en = out_q.pwr_en;
  assign ram_pwr_en  = out_q.ram_en;
  assign core_rst    = out_q.rst;
  assign iso_req     = out_q.iso;
  assign state_code  = out_q.code;
endmodule

// File: rtl/cps_chk.sv
module cps_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       evt,
  input logic       sev,
  input logic       snoop_req,
  input logic       plugin_req,
  input logic       core_clk_en,
  input logic       core_pwr_en,
  input logic       ram_pwr_en,
  input logic       core_rst,
  input logic       iso_req,
  input logic [2:0] state_code
);
  logic wk;
  assign wk = irq | evt | sev | snoop_req;

  // R2
  stby_gated_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd1 |-> !core_clk_en && core_pwr_en && ram_pwr_en);

  // R4
  stby_exit_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'd1 && $past(wk)) |-> (state_code == 3'd5 && !core_clk_en));

  // R4
  stby_exit_second_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code, 2) == 3'd1 && $past(wk, 2)) |-> (state_code == 3'd0 && core_clk_en));

  // R6
  pwr_off_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_pwr_en) |-> iso_req && $past(iso_req));

  // R7
  dorm_domains_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd2 |-> !core_pwr_en && ram_pwr_en && iso_req);

  // R8
  pdn_domains_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd3 |-> !core_pwr_en && !ram_pwr_en);

  // R9
  unplug_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd4 && !plugin_req) |=> state_code == 3'd4);

  // R11
  restore_in_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_pwr_en) |-> core_rst && !core_clk_en);

  // R11
  clk_rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> !core_rst);
endmodule

bind core_pwr_seq cps_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .evt        (evt),
  .sev        (sev),
  .snoop_req  (snoop_req),
  .plugin_req (plugin_req),
  .core_clk_en(core_clk_en),
  .core_pwr_en(core_pwr_en),
  .ram_pwr_en (ram_pwr_en),
  .core_rst   (core_rst),
  .iso_req    (iso_req),
  .state_code (state_code)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi_req = 0, wfe_req = 0, irq = 0, evt = 0, sev = 0, snoop_req = 0;
  logic dormant_req = 0, pdown_req = 0, unplug_req = 0, plugin_req = 0;
  logic save_done = 0, pwr_good = 0, iso_ack = 0;
  logic core_clk_en, core_pwr_en, ram_pwr_en, core_rst, iso_req;
  logic [2:0] state_code;

  always #5 clk = ~clk;

  core_pwr_seq #(.RST_CYC(4)) u_dut (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .irq(irq), .evt(evt), .sev(sev), .snoop_req(snoop_req),
    .dormant_req(dormant_req), .pdown_req(pdown_req),
    .unplug_req(unplug_req), .plugin_req(plugin_req),
    .save_done(save_done), .pwr_good(pwr_good), .iso_ack(iso_ack),
    .core_clk_en(core_clk_en), .core_pwr_en(core_pwr_en),
    .ram_pwr_en(ram_pwr_en), .core_rst(core_rst), .iso_req(iso_req),
    .state_code(state_code)
  );

  // {clk_en, pwr_en, ram_en, rst, iso, code[2:0]}
  localparam logic [7:0] V_RUN  = 8'b11100_000;
  localparam logic [7:0] V_STBY = 8'b01100_001;
  localparam logic [7:0] V_TR   = 8'b01100_101;
  localparam logic [7:0] V_ISO  = 8'b11101_101;
  localparam logic [7:0] V_DORM = 8'b00111_010;
  localparam logic [7:0] V_PDN  = 8'b00011_011;
  localparam logic [7:0] V_UNPL = 8'b00011_100;
  localparam logic [7:0] V_PUP  = 8'b01111_101;

  typedef struct {
    string      req;
    logic [7:0] v;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic step(input string r, input logic [7:0] v);
    item_t it;
    @(posedge clk); #1;
    it.req = r;
    it.v   = v;
    sb.push_back(it);
  endtask

  task automatic restore(input string r);
    pwr_good = 1;
    for (int i = 0; i < 4; i++) step(r, V_PUP);
    step(r, V_RUN);
    pwr_good = 0;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = sb.pop_front();
      got = {core_clk_en, core_pwr_en, ram_pwr_en, core_rst, iso_req, state_code};
      checks++;
      if (got !== it.v) begin
        errors++;
        $display("FAIL %s: got %b expected %b at %0t", it.req, got, it.v, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    step("R1", V_RUN);
    rst = 0;
    step("R1", V_RUN);

    // R2 R3 R4: standby entry and each wake source
    wfi_req = 1; step("R2", V_STBY); wfi_req = 0;
    step("R3", V_STBY);
    irq = 1; step("R4", V_TR); irq = 0;
    step("R4", V_RUN);
    wfe_req = 1; step("R2", V_STBY); wfe_req = 0;
    sev = 1; step("R3", V_TR); sev = 0;
    step("R3", V_RUN);
    wfi_req = 1; step("R2", V_STBY); wfi_req = 0;
    snoop_req = 1; step("R3", V_TR); snoop_req = 0;
    step("R3", V_RUN);
    wfe_req = 1; step("R2", V_STBY); wfe_req = 0;
    evt = 1; step("R3", V_TR); evt = 0;
    step("R4", V_RUN);

    // R5: wait request with wake pending
    wfi_req = 1; irq = 1; step("R5", V_RUN);
    step("R5", V_RUN); wfi_req = 0; irq = 0;
    step("R5", V_RUN);

    // R6 R7 R11: dormant round trip
    dormant_req = 1; step("R6", V_ISO); dormant_req = 0;
    step("R6", V_ISO);
    iso_ack = 1; step("R6", V_ISO); iso_ack = 0;
    step("R6", V_ISO);
    save_done = 1; step("R7", V_DORM); save_done = 0;
    snoop_req = 1; step("R7", V_DORM); snoop_req = 0;
    irq = 1; step("R11", V_PUP); irq = 0;
    step("R11", V_PUP);
    restore("R11");

    // R10: abort while waiting for save-done
    pdown_req = 1; step("R10", V_ISO); pdown_req = 0;
    iso_ack = 1; step("R10", V_ISO); iso_ack = 0;
    evt = 1; step("R10", V_RUN); evt = 0;
    // R10: abort while waiting for isolation acknowledge
    dormant_req = 1; step("R10", V_ISO); dormant_req = 0;
    irq = 1; step("R10", V_RUN); irq = 0;
    step("R10", V_RUN);

    // R12 R8: power-down wins over dormant
    dormant_req = 1; pdown_req = 1; step("R12", V_ISO);
    dormant_req = 0; pdown_req = 0;
    iso_ack = 1; step("R12", V_ISO); iso_ack = 0;
    save_done = 1; step("R12", V_PDN); save_done = 0;
    step("R8", V_PDN);
    sev = 1; step("R8", V_PUP); sev = 0;
    restore("R8");

    // R9 R12: hot-unplug wins over power-down, ignores interrupts
    unplug_req = 1; pdown_req = 1; step("R12", V_ISO);
    unplug_req = 0; pdown_req = 0;
    iso_ack = 1; step("R9", V_ISO); iso_ack = 0;
    irq = 1; step("R9", V_ISO); irq = 0;
    save_done = 1; step("R9", V_UNPL); save_done = 0;
    irq = 1; evt = 1; sev = 1; snoop_req = 1;
    step("R9", V_UNPL);
    step("R9", V_UNPL);
    irq = 0; evt = 0; sev = 0; snoop_req = 0;
    plugin_req = 1; step("R9", V_PUP); plugin_req = 0;
    restore("R11");

    tick(); tick();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule